// File: doc/BRIEF.md
# AHB-Lite Register Bridge

This block is an AHB-Lite subordinate that sits in front of a file of 32-bit control and status registers. It samples each selected address phase and, in the data phase that follows, turns it into exactly one access on a simple request/acknowledge register port. The register side may stretch an access over several cycles by holding its acknowledge low. The bridge passes those stalls back to the bus as wait states.

The bus address and data widths are parameters, defaulting to 32-bit address and 64-bit data. Every register is one 32-bit word, so only the low 32 bits of the address and of the write data reach the register port. Read data comes back in the low word of the read bus. Only single non-sequential transfers are served. A sequential transfer, or an access the register file rejects, is answered with the two-cycle ERROR response.

Top module: `ahb_reg_bridge`

## Requirements
- R1: A selected address phase with HREADY high and transfer type NONSEQ (2'b10) leads to exactly one register access in the next cycle. reg_addr carries the low 32 bits of the sampled address, and reg_we and reg_size carry the sampled write flag and size.
- R2: During a write access, reg_wdata equals HWDATA[31:0] of the data phase. HWDATA bits above 31 have no effect on the stored word.
- R3: On a completed read, HRDATA[31:0] holds the register word. HRDATA bits above 31 are always zero.
- R4: While reg_req is high and reg_ack is low, HREADYOUT stays low. The transfer completes in the first cycle in which reg_ack is high.
- R5: A transfer of type IDLE (2'b00) or BUSY (2'b01), or any address phase with HSEL low, causes no register access. It is answered with HREADYOUT high and HRESP low (OKAY).
- R6: A selected SEQ (2'b11) transfer causes no register access. It is answered with one cycle of HREADYOUT low and HRESP high, followed by one cycle of HREADYOUT high and HRESP high.
- R7: When the register port acknowledges with reg_err high, the bridge answers with the same two-cycle ERROR response that R6 describes.
- R8: A new address phase is accepted in the same cycle that the previous data phase completes. N back-to-back zero-wait transfers finish N+1 cycles after the first address phase is presented.
- R9: In reset, HREADYOUT is high, HRESP is low, reg_req is low and HRDATA is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsel | input | 1 | Subordinate select |
| haddr | input | ADDR_W | Transfer address |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | 1 = write, 0 = read |
| hsize | input | 3 | Transfer size |
| hwdata | input | DATA_W | Write data (data phase) |
| hready | input | 1 | Bus-wide ready, high when the previous data phase ends |
| hreadyout | output | 1 | Ready from this subordinate |
| hresp | output | 1 | 0 = OKAY, 1 = ERROR |
| hrdata | output | DATA_W | Read data, upper bits zero |
| reg_req | output | 1 | Register access in progress |
| reg_we | output | 1 | Register write enable |
| reg_addr | output | 32 | Register byte address |
| reg_size | output | 3 | Sampled transfer size |
| reg_wdata | output | 32 | Register write data |
| reg_rdata | input | 32 | Register read data |
| reg_ack | input | 1 | Register access done |
| reg_err | input | 1 | Register access rejected (valid with reg_ack) |

## Verification
Two things can happen in the same cycle: a data phase finishes, and the next address phase is sampled. The bench provokes this by issuing writes and reads to the same register back to back, with no idle cycle between them. Each read must return the word that the preceding write stored. The whole burst must also finish exactly one cycle after its last address phase. Sampling the address one cycle late or one cycle early would show up as a wrong read value or as a changed cycle count.

// File: rtl/ahb_reg_pkg.sv
package ahb_reg_pkg;

  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    HT_IDLE   = 2'b00,
    HT_BUSY   = 2'b01,
    HT_NONSEQ = 2'b10,
    HT_SEQ    = 2'b11
  } htrans_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ACCESS,
    PH_ERR_FIRST,
    PH_ERR_LAST
  } phase_e;

  typedef struct packed {
    logic [REG_W-1:0] addr;
    logic             write;
    logic [2:0]       size;
  } addr_phase_t;

endpackage

// File: rtl/ahb_reg_addr_cap.sv
module ahb_reg_addr_cap
  import ahb_reg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [ADDR_W-1:0] haddr,
  input  logic              hwrite,
  input  logic [2:0]        hsize,
  output addr_phase_t       cap_q
);

  logic [REG_W-1:0] addr_lo;
  addr_phase_t      cap_d;

  generate
    if (ADDR_W > REG_W) begin : g_wide
      logic unused_hi;
      assign addr_lo   = haddr[REG_W-1:0];
      assign unused_hi = ^haddr[ADDR_W-1:REG_W];
    end else if (ADDR_W == REG_W) begin : g_exact
      assign addr_lo = haddr;
    end else begin : g_narrow
      assign addr_lo = {{(REG_W-ADDR_W){1'b0}}, haddr};
    end
  endgenerate

  always_comb begin
    cap_d = cap_q;
    if (cap_en) begin
      cap_d.addr  = addr_lo;
      cap_d.write = hwrite;
      cap_d.size  = hsize;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
    end else begin
      cap_q <= cap_d;
    end
  end

endmodule

// File: rtl/ahb_reg_phase_ctrl.sv
module ahb_reg_phase_ctrl
  import ahb_reg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_access,
  input  logic start_reject,
  input  logic reg_ack,
  input  logic reg_err,
  output logic reg_req,
  output logic hreadyout,
  output logic hresp
);

  phase_e state_q, state_d;
  logic   access_ok;
  logic   phase_end;

  assign access_ok = (state_q == PH_ACCESS) && reg_ack && !reg_err;
  assign phase_end = (state_q == PH_IDLE) || (state_q == PH_ERR_LAST) || access_ok;

  always_comb begin
    state_d = state_q;
    if (phase_end) begin
      if (start_access) begin
        state_d = PH_ACCESS;
      end else if (start_reject) begin
        state_d = PH_ERR_FIRST;
      end else begin
        state_d = PH_IDLE;
      end
    end else begin
      unique case (state_q)
        PH_ACCESS:    state_d = (reg_ack && reg_err) ? PH_ERR_LAST : PH_ACCESS;
        PH_ERR_FIRST: state_d = PH_ERR_LAST;
        default:      state_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_comb begin
    reg_req   = 1'b0;
    hreadyout = 1'b1;
    hresp     = 1'b0;
    unique case (state_q)
      PH_ACCESS: begin
        reg_req   = 1'b1;
        hreadyout = reg_ack && !reg_err;
        hresp     = reg_ack && reg_err;
      end
      PH_ERR_FIRST: begin
        hreadyout = 1'b0;
        hresp     = 1'b1;
      end
      PH_ERR_LAST: begin
        hreadyout = 1'b1;
        hresp     = 1'b1;
      end
      default: begin
        hreadyout = 1'b1;
        hresp     = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/ahb_reg_rdata_pack.sv
module ahb_reg_rdata_pack
  import ahb_reg_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              rd_valid,
  input  logic [REG_W-1:0]  rd_word,
  output logic [DATA_W-1:0] hrdata
);

  logic [REG_W-1:0] word_gated;

  assign word_gated = rd_valid ? rd_word : '0;

  generate
    if (DATA_W > REG_W) begin : g_pad
      assign hrdata = {{(DATA_W-REG_W){1'b0}}, word_gated};
    end else begin : g_fit
      assign hrdata = word_gated;
    end
  endgenerate

endmodule

// File: rtl/ahb_reg_bridge.sv
module ahb_reg_bridge
  import ahb_reg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsel,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic [2:0]        hsize,
  input  logic [DATA_W-1:0] hwdata,
  input  logic              hready,
  output logic              hreadyout,
  output logic              hresp,
  output logic [DATA_W-1:0] hrdata,
  output logic              reg_req,
  output logic              reg_we,
  output logic [31:0]       reg_addr,
  output logic [2:0]        reg_size,
  output logic [31:0]       reg_wdata,
  input  logic [31:0]       reg_rdata,
  input  logic              reg_ack,
  input  logic              reg_err
);

  localparam int WD_LO = REG_W;

  logic        phase_take;
  logic        start_access;
  logic        start_reject;
  logic        rd_valid;
  addr_phase_t cap_q;

  assign phase_take   = hsel && hready;
  assign start_access = phase_take && (htrans_e'(htrans) == HT_NONSEQ);
  assign start_reject = phase_take && (htrans_e'(htrans) == HT_SEQ);

  ahb_reg_addr_cap #(.ADDR_W(ADDR_W)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_en (start_access),
    .haddr  (haddr),
    .hwrite (hwrite),
    .hsize  (hsize),
    .cap_q  (cap_q)
  );

  ahb_reg_phase_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_access (start_access),
    .start_reject (start_reject),
    .reg_ack      (reg_ack),
    .reg_err      (reg_err),
    .reg_req      (reg_req),
    .hreadyout    (hreadyout),
    .hresp        (hresp)
  );

  assign reg_addr  = cap_q.addr;
  assign reg_we    = cap_q.write;
  assign reg_size  = cap_q.size;
  assign reg_wdata = hwdata[WD_LO-1:0];

  generate
    if (DATA_W > WD_LO) begin : g_wd_hi
      logic unused_wd_hi;
      assign unused_wd_hi = ^hwdata[DATA_W-1:WD_LO];
    end
  endgenerate

  assign rd_valid = reg_req && reg_ack && !reg_err && !cap_q.write;

  ahb_reg_rdata_pack #(.DATA_W(DATA_W)) u_pack (
    .rd_valid (rd_valid),
    .rd_word  (reg_rdata),
    .hrdata   (hrdata)
  );

endmodule

// File: rtl/ahb_reg_bridge_chk.sv
module ahb_reg_bridge_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hsel,
  input logic              hready,
  input logic [1:0]        htrans,
  input logic              hreadyout,
  input logic              hresp,
  input logic [DATA_W-1:0] hrdata,
  input logic              reg_req,
  input logic              reg_ack
);

  assert_nonseq_access_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (hsel && hready && htrans == 2'b10) |=> reg_req);

  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hrdata[DATA_W-1:32] == '0);

  assert_wait_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_ack) |-> !hreadyout);

  assert_idle_okay_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hready && (!hsel || !htrans[1])) |=> (!reg_req && hreadyout && !hresp));

  assert_seq_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hsel && hready && htrans == 2'b11) |=> (!reg_req && !hreadyout && hresp));

  // R6 and R7: an ERROR first cycle is always followed by the ready ERROR cycle
  assert_err_second_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hresp && !hreadyout) |=> (hresp && hreadyout));

endmodule

bind ahb_reg_bridge ahb_reg_bridge_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hsel      (hsel),
  .hready    (hready),
  .htrans    (htrans),
  .hreadyout (hreadyout),
  .hresp     (hresp),
  .hrdata    (hrdata),
  .reg_req   (reg_req),
  .reg_ack   (reg_ack)
);

// File: tb/ahb_reg_bridge_bench.sv
module ahb_reg_bridge_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;
  localparam int DATA_W     = 64;
  localparam int NREG       = 16;

  logic              clk;
  logic              rst_n;
  logic              hsel;
  logic [ADDR_W-1:0] haddr;
  logic [1:0]        htrans;
  logic              hwrite;
  logic [2:0]        hsize;
  logic [DATA_W-1:0] hwdata;
  logic              hready;
  logic              hreadyout;
  logic              hresp;
  logic [DATA_W-1:0] hrdata;
  logic              reg_req;
  logic              reg_we;
  logic [31:0]       reg_addr;
  logic [2:0]        reg_size;
  logic [31:0]       reg_wdata;
  logic [31:0]       reg_rdata;
  logic              reg_ack;
  logic              reg_err;

  assign hready = hreadyout;

  ahb_reg_bridge #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ahb_reg_bridge (
    .clk(clk), .rst_n(rst_n), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata), .hready(hready),
    .hreadyout(hreadyout), .hresp(hresp), .hrdata(hrdata),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_size(reg_size),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ack(reg_ack), .reg_err(reg_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // register file stand-in: 16 words, programmable wait, error outside 0x00..0x3F
  logic [31:0] mem [NREG];
  int wcnt;
  int wait_cfg = 0;
  int acc_cnt;

  assign reg_err   = (reg_addr[31:6] != 26'd0);
  assign reg_ack   = reg_req && (wcnt == wait_cfg);
  assign reg_rdata = mem[reg_addr[5:2]];

  always @(posedge clk) begin
    if (!rst_n) begin
      wcnt    <= 0;
      acc_cnt <= 0;
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else begin
      if (reg_req && !reg_ack) wcnt <= wcnt + 1;
      else                     wcnt <= 0;
      if (reg_req && reg_ack) begin
        acc_cnt <= acc_cnt + 1;
        if (reg_we && !reg_err) mem[reg_addr[5:2]] <= reg_wdata;
      end
    end
  end

  typedef struct {
    logic        rd;
    logic        err;
    logic [31:0] data;
    int          waits;
    string       tag;
  } item_t;

  item_t       exp_q[$];
  logic [31:0] shadow [NREG];
  bit          pend = 1'b0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: judges each data phase at the falling edge before it completes
  initial begin
    item_t cur;
    int    waited;
    bit    saw_err_low;
    waited = 0;
    saw_err_low = 1'b0;
    forever begin
      @(negedge clk);
      if (pend) begin
        if (!hreadyout) begin
          waited++;
          if (hresp) saw_err_low = 1'b1;
        end else begin
          check(hresp == cur.err, cur.tag, 64'(hresp), 64'(cur.err));
          check(waited == cur.waits, cur.tag, 64'(waited), 64'(cur.waits));
          if (cur.err)
            check(saw_err_low, cur.tag, 64'(saw_err_low), 64'd1);
          else if (cur.rd)
            check(hrdata == {32'd0, cur.data}, cur.tag, hrdata, {32'd0, cur.data});
          pend = 1'b0;
        end
      end
      if (rst_n && hreadyout && hsel && htrans[1]) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R1 unexpected transfer", 64'd1, 64'd0);
        end else begin
          cur = exp_q.pop_front();
          pend = 1'b1;
          waited = 0;
          saw_err_low = 1'b0;
        end
      end
    end
  end

  // driver: presents one address phase, queues its expected result
  task automatic xfer(input logic [1:0] tr, input logic wr, input logic [31:0] addr,
                      input logic [63:0] wdata, input string tag, input logic sel = 1'b1);
    item_t it;
    if (sel && tr[1]) begin
      it.tag = tag;
      it.rd  = !wr;
      it.data = '0;
      if (tr == 2'b11) begin
        it.err = 1'b1;
        it.waits = 1;
      end else begin
        it.err   = (addr[31:6] != 26'd0);
        it.waits = it.err ? wait_cfg + 1 : wait_cfg;
        if (!it.err) begin
          it.data = shadow[addr[5:2]];
          if (wr) shadow[addr[5:2]] = wdata[31:0];
        end
      end
      exp_q.push_back(it);
    end
    hsel   = sel;
    htrans = tr;
    haddr  = addr;
    hwrite = wr;
    hsize  = 3'b010;
    do @(negedge clk); while (!hreadyout);
    @(posedge clk);
    #1;
    hwdata = wdata;
    htrans = 2'b00;
    hsel   = 1'b1;
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || pend) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int acc0;
    int c0;
    for (int i = 0; i < NREG; i++) shadow[i] = '0;
    rst_n = 1'b0;
    hsel = 1'b0; haddr = '0; htrans = 2'b00; hwrite = 1'b0; hsize = 3'b010; hwdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset values
    check(hreadyout && !hresp && !reg_req && hrdata == '0, "R9 reset state",
          {hrdata[31:0], 29'd0, hreadyout, hresp, reg_req}, 64'd4);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(posedge clk);
    #1;

    // R1 R2: writes with junk in upper write-data bits
    wait_cfg = 0;
    for (int i = 0; i < 4; i++)
      xfer(2'b10, 1'b1, 32'(i*4), {32'hA5A5_0000 + 32'(i), 32'h1234_5600 + 32'(i)}, "R2 write");
    drain();
    check(acc_cnt == 4, "R1 access count", 64'(acc_cnt), 64'd4);
    check(mem[2] == 32'h1234_5602, "R2 stored low word", 64'(mem[2]), 64'h1234_5602);

    // R3: reads return low word, upper zero
    for (int i = 3; i >= 0; i--) xfer(2'b10, 1'b0, 32'(i*4), 64'hFFFF_FFFF_FFFF_FFFF, "R3 read");
    drain();

    // R4: wait states
    wait_cfg = 2;
    xfer(2'b10, 1'b1, 32'h14, 64'h0000_0001_CAFE_F00D, "R4 write wait");
    xfer(2'b10, 1'b0, 32'h14, 64'd0, "R4 read wait");
    drain();
    wait_cfg = 0;

    // R5: IDLE, BUSY, unselected
    acc0 = acc_cnt;
    xfer(2'b00, 1'b1, 32'h8, 64'hDEAD, "R5");
    @(negedge clk);
    check(hreadyout && !hresp && !reg_req, "R5 idle okay", {61'd0, hreadyout, hresp, reg_req}, 64'd4);
    xfer(2'b01, 1'b1, 32'h8, 64'hDEAD, "R5");
    @(negedge clk);
    check(hreadyout && !hresp && !reg_req, "R5 busy okay", {61'd0, hreadyout, hresp, reg_req}, 64'd4);
    xfer(2'b10, 1'b1, 32'h8, 64'hDEAD, "R5", 1'b0);
    @(negedge clk);
    check(hreadyout && !hresp && !reg_req, "R5 unselected", {61'd0, hreadyout, hresp, reg_req}, 64'd4);
    drain();
    check(acc_cnt == acc0, "R5 no access", 64'(acc_cnt), 64'(acc0));
    xfer(2'b10, 1'b0, 32'h8, 64'd0, "R5 reg unchanged");
    drain();

    // R6: SEQ rejected
    acc0 = acc_cnt;
    xfer(2'b11, 1'b1, 32'h0, 64'hBAD, "R6 seq error");
    drain();
    check(acc_cnt == acc0, "R6 no access", 64'(acc_cnt), 64'(acc0));
    xfer(2'b10, 1'b0, 32'h0, 64'd0, "R6 reg unchanged");
    drain();

    // R7: register-side error
    xfer(2'b10, 1'b0, 32'h100, 64'd0, "R7 err read");
    drain();
    wait_cfg = 1;
    xfer(2'b10, 1'b1, 32'h200, 64'h77, "R7 err write wait");
    drain();
    wait_cfg = 0;

    // R8: back-to-back, address and data phases overlapping
    c0 = cyc;
    xfer(2'b10, 1'b1, 32'h1C, 64'h0000_0000_1111_2222, "R8 b2b write");
    xfer(2'b10, 1'b0, 32'h1C, 64'd0, "R8 b2b read");
    xfer(2'b10, 1'b1, 32'h20, 64'h0000_0000_3333_4444, "R8 b2b write");
    xfer(2'b10, 1'b0, 32'h20, 64'd0, "R8 b2b read");
    drain();
    check(cyc - c0 == 5, "R8 cycle count", 64'(cyc - c0), 64'd5);

    repeat (2) @(posedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule